// File: doc/BRIEF.md
# Multi-channel ADC word serializer

This block turns one parallel sample word per channel into a bit stream on a separate serial line for each channel. All channels share a word-rate load strobe and run in one fast clock domain at twelve times the word rate. A full word therefore leaves in exactly twelve ticks, least significant bit first. Samples are unsigned straight binary, from code 0 up to full scale 4095.

Two reference lines travel with the data so that a receiver can capture it. One is a bit clock at half the tick rate, giving an edge per data bit for double-data-rate capture. The other is a frame clock at the word rate. A word marker flags the first bit slot of each word. The reference lines are built as rotating bit patterns in the same registered shift lanes as the samples, so they keep the same latency as the data. A strobe that breaks the twelve-tick grid sets a sticky misalignment flag.

Top module: `adc_word_serializer`

## Requirements
- R1: The tick after an edge where `load_i` is high, every `sdata_o` line carries bit 0 of its channel's word from `word_i`. Channel c occupies `word_i[c*12 +: 12]`.
- R2: The word leaves least significant bit first. In bit slot k (k = 0..11, counted from the tick after the load edge), each line carries bit k, and all channels move in lockstep.
- R3: `bclk_o` is low in even slots and high in odd slots, so it toggles on every tick.
- R4: `fclk_o` is high in slots 0 to 5 and low in slots 6 to 11.
- R5: `word_mark_o` is high in slot 0 only. It coincides with high `fclk_o` and low `bclk_o`.
- R6: Every 12-bit code from 0 to 4095, including 0 and 4095, comes back unchanged when the bench reassembles the twelve slots.
- R7: After reset, the data lines, `bclk_o`, `fclk_o`, `word_mark_o` and `misalign_err_o` are low, and they stay low until the first load.
- R8: If no new load comes, the data lines are low from slot 12 on. The bit clock, frame clock and marker keep repeating their 12-slot patterns.
- R9: A strobe that comes earlier or later than 12 ticks after the previous one raises `misalign_err_o` one tick later. The first strobe after reset never raises it.
- R10: `misalign_err_o` stays high until reset. An off-grid strobe still loads its word and restarts the slot sequence from it.
- R11: Strobes placed exactly every 12 ticks never raise `misalign_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, twelve times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Word-rate load strobe |
| word_i | input | NUM_CH*WORD_W (96) | Parallel words, channel c in bits c*WORD_W upward |
| sdata_o | output | NUM_CH (8) | Serial data line per channel |
| bclk_o | output | 1 | Bit clock, one edge per data bit |
| fclk_o | output | 1 | Frame clock, high in the first half of each word |
| word_mark_o | output | 1 | High in the slot carrying bit 0 |
| misalign_err_o | output | 1 | Sticky flag for an off-grid load strobe |

## Verification
The bench uses the default build of eight channels of 12 bits. A code space of 4096 values is small enough to cover completely. Channel c in sweep frame f carries code (8f + c) mod 4096, so the eight lanes together send every code once in 512 frames, after an all-ones frame and an all-zeros frame. The same build also covers draining after the last word, a late strobe, an early strobe that restarts the slot sequence, and clearing of the sticky flag by reset.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int unsigned DEF_CH = 8;
    localparam int unsigned DEF_W  = 12;

    // Lane behaviour when bits are shifted out
    typedef enum logic [0:0] {
        LANE_DRAIN  = 1'b0,   // zero fill: a word leaves once
        LANE_ROTATE = 1'b1    // recirculate: a fixed pattern repeats
    } lane_kind_e;

    // Bit clock: low in even slots, high in odd slots
    function automatic logic [63:0] bclk_pattern(input int unsigned w);
        logic [63:0] p;
        p = '0;
        for (int unsigned i = 0; i < w; i++) p[i] = i[0];
        return p;
    endfunction

    // Frame clock: high over the first half of a word
    function automatic logic [63:0] fclk_pattern(input int unsigned w);
        logic [63:0] p;
        p = '0;
        for (int unsigned i = 0; i < w; i++) p[i] = (i < w / 2);
        return p;
    endfunction

    // Marker: only slot 0
    function automatic logic [63:0] mark_pattern(input int unsigned w);
        logic [63:0] p;
        p = '0;
        if (w > 0) p[0] = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/ser_lane.sv
module ser_lane
    import ser_pkg::*;
#(
    parameter int unsigned W    = DEF_W,
    parameter lane_kind_e  KIND = LANE_DRAIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         q
);

    logic [W-1:0] sh;
    logic         fill_load;
    logic         fill_shift;

    generate
        if (KIND == LANE_ROTATE) begin : g_rot
            assign fill_load  = din[0];
            assign fill_shift = sh[0];
        end else begin : g_drain
            assign fill_load  = 1'b0;
            assign fill_shift = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
            q  <= 1'b0;
        end else if (load) begin
            q  <= din[0];
            sh <= {fill_load, din[W-1:1]};
        end else begin
            q  <= sh[0];
            sh <= {fill_shift, sh[W-1:1]};
        end
    end

    // R1
    load_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din[0])));

endmodule

// File: rtl/ser_phase_mon.sv
module ser_phase_mon
    import ser_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic err
);

    localparam int unsigned CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [CW-1:0] SAT  = CW'(W);

    logic [CW-1:0] ticks;
    logic          seen;
    logic          off_grid;

    assign off_grid = load && seen && (ticks != LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks <= '0;
            seen  <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (load) begin
                ticks <= '0;
                seen  <= 1'b1;
            end else if (ticks != SAT) begin
                ticks <= ticks + 1'b1;
            end
            if (off_grid) err <= 1'b1;
        end
    end

    // R9
    first_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !seen) |=> (err == $past(err)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/adc_word_serializer.sv
module adc_word_serializer
    import ser_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_CH,
    parameter int unsigned WORD_W = DEF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic [NUM_CH*WORD_W-1:0]   word_i,
    output logic [NUM_CH-1:0]          sdata_o,
    output logic                       bclk_o,
    output logic                       fclk_o,
    output logic                       word_mark_o,
    output logic                       misalign_err_o
);

    localparam logic [WORD_W-1:0] BCLK_PAT = WORD_W'(bclk_pattern(WORD_W));
    localparam logic [WORD_W-1:0] FCLK_PAT = WORD_W'(fclk_pattern(WORD_W));
    localparam logic [WORD_W-1:0] MARK_PAT = WORD_W'(mark_pattern(WORD_W));

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            ser_lane #(.W(WORD_W), .KIND(LANE_DRAIN)) u_lane (
                .clk  (clk),
                .rst  (rst),
                .load (load_i),
                .din  (word_i[c*WORD_W +: WORD_W]),
                .q    (sdata_o[c])
            );
        end
    endgenerate

    ser_lane #(.W(WORD_W), .KIND(LANE_ROTATE)) u_bclk (
        .clk(clk), .rst(rst), .load(load_i), .din(BCLK_PAT), .q(bclk_o)
    );

    ser_lane #(.W(WORD_W), .KIND(LANE_ROTATE)) u_fclk (
        .clk(clk), .rst(rst), .load(load_i), .din(FCLK_PAT), .q(fclk_o)
    );

    ser_lane #(.W(WORD_W), .KIND(LANE_ROTATE)) u_mark (
        .clk(clk), .rst(rst), .load(load_i), .din(MARK_PAT), .q(word_mark_o)
    );

    ser_phase_mon #(.W(WORD_W)) u_mon (
        .clk  (clk),
        .rst  (rst),
        .load (load_i),
        .err  (misalign_err_o)
    );

    // R3
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        bclk_o |=> !bclk_o);

    // R5
    mark_phase_chk: assert property (@(posedge clk) disable iff (rst)
        word_mark_o |-> (fclk_o && !bclk_o));

    // R5
    mark_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_mark_o |=> !word_mark_o);

    // R8
    drained_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (word_mark_o && !$past(load_i)) |-> (sdata_o == '0));

endmodule

// File: tb/sim_adc_word_serializer.sv
module sim_adc_word_serializer;

    localparam int NCH = 8;
    localparam int WW  = 12;
    localparam int NF  = 2 + (1 << WW) / NCH;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                      rst;
    logic                      load_i;
    logic [NCH-1:0][WW-1:0]    word_drv;
    logic [NCH-1:0]            sdata_o;
    logic                      bclk_o, fclk_o, word_mark_o, misalign_err_o;

    adc_word_serializer #(.NUM_CH(NCH), .WORD_W(WW)) u0 (
        .clk            (clk),
        .rst            (rst),
        .load_i         (load_i),
        .word_i         (word_drv),
        .sdata_o        (sdata_o),
        .bclk_o         (bclk_o),
        .fclk_o         (fclk_o),
        .word_mark_o    (word_mark_o),
        .misalign_err_o (misalign_err_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [NCH-1:0][WW-1:0] acc;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NCH-1:0][WW-1:0] gen(input int f);
        logic [NCH-1:0][WW-1:0] w;
        for (int ch = 0; ch < NCH; ch++) begin
            if (f == 0)      w[ch] = '1;
            else if (f == 1) w[ch] = '0;
            else             w[ch] = WW'(((f - 2) * NCH + ch) % (1 << WW));
        end
        return w;
    endfunction

    // Observe one slot of a word; reassemble and compare after the last slot
    task automatic obs(input logic [NCH-1:0][WW-1:0] w, input int slot);
        for (int ch = 0; ch < NCH; ch++) begin
            acc[ch][slot] = sdata_o[ch];
            if (slot == 0)
                chk(sdata_o[ch] == w[ch][0], "R1 bit0", sdata_o[ch], w[ch][0]);
            else
                chk(sdata_o[ch] == w[ch][slot], "R2 slot bit", sdata_o[ch], w[ch][slot]);
        end
        chk(bclk_o == slot[0], "R3 bclk", bclk_o, slot[0]);
        chk(fclk_o == (slot < WW / 2), "R4 fclk", fclk_o, int'(slot < WW / 2));
        chk(word_mark_o == (slot == 0), "R5 mark", word_mark_o, int'(slot == 0));
        if (slot == WW - 1)
            for (int ch = 0; ch < NCH; ch++)
                chk(acc[ch] == w[ch], "R6 round trip", acc[ch], w[ch]);
    endtask

    task automatic run_frames();
        logic [NCH-1:0][WW-1:0] cur;
        logic [NCH-1:0][WW-1:0] prv;
        cur = '0;
        prv = '0;
        for (int f = 0; f < NF; f++) begin
            for (int k = 0; k < WW; k++) begin
                @(negedge clk);
                if (k == 0 && f > 0) obs(prv, WW - 1);
                else if (k > 0)      obs(cur, k - 1);
                if (k == 0) begin
                    cur      = gen(f);
                    word_drv = cur;
                    load_i   = 1'b1;
                end else begin
                    load_i = 1'b0;
                end
                if (k == WW - 1) prv = cur;
            end
        end
        @(negedge clk);
        obs(cur, WW - 1);
        load_i = 1'b0;
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        load_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NCH-1:0][WW-1:0] wa, wb;
        word_drv = '0;
        do_reset();

        // R7: idle after reset, everything low until the first load
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(sdata_o == '0, "R7 data low", sdata_o, 0);
            chk(!bclk_o && !fclk_o && !word_mark_o, "R7 clocks low",
                {bclk_o, fclk_o, word_mark_o}, 0);
            chk(!misalign_err_o, "R7 err low", misalign_err_o, 0);
        end

        // R1 R2 R3 R4 R5 R6: full code sweep with strobes every 12 ticks
        run_frames();
        // R9 R11: first strobe and on-grid strobes leave the flag low
        chk(!misalign_err_o, "R11 no error on grid", misalign_err_o, 0);

        // R8: no further load, data drains, patterns keep running
        for (int i = 0; i < 2 * WW; i++) begin
            @(negedge clk);
            chk(sdata_o == '0, "R8 drained", sdata_o, 0);
            chk(bclk_o == i[0], "R8 bclk runs", bclk_o, i[0]);
            chk(fclk_o == ((i % WW) < WW / 2), "R8 fclk runs", fclk_o,
                int'((i % WW) < WW / 2));
            chk(word_mark_o == ((i % WW) == 0), "R8 mark runs", word_mark_o,
                int'((i % WW) == 0));
        end

        // R9 R10: late strobe flags the error, word still loaded
        wa = gen(40);
        word_drv = wa;
        load_i   = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        chk(misalign_err_o, "R9 late strobe", misalign_err_o, 1);
        for (int ch = 0; ch < NCH; ch++)
            chk(sdata_o[ch] == wa[ch][0], "R10 late word loaded", sdata_o[ch], wa[ch][0]);
        repeat (15) @(negedge clk);
        chk(misalign_err_o, "R10 sticky", misalign_err_o, 1);

        // R7 R10: reset clears the flag
        do_reset();
        @(negedge clk);
        chk(!misalign_err_o, "R10 cleared by reset", misalign_err_o, 0);
        chk(sdata_o == '0 && !fclk_o && !bclk_o, "R7 after reset",
            {sdata_o, fclk_o, bclk_o}, 0);

        // R9 R10: early strobe restarts the sequence from the new word
        wa = gen(77);
        wb = gen(300);
        word_drv = wa;
        load_i   = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        obs(wa, 0);
        chk(!misalign_err_o, "R9 first strobe clean", misalign_err_o, 0);
        for (int k = 1; k < 5; k++) begin
            @(negedge clk);
            obs(wa, k);
            if (k == 4) begin
                word_drv = wb;
                load_i   = 1'b1;
            end
        end
        for (int k = 0; k < WW; k++) begin
            @(negedge clk);
            load_i = 1'b0;
            obs(wb, k);
            chk(misalign_err_o, "R9 early strobe", misalign_err_o, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule